// File: doc/BRIEF.md
# Handshaked Bus Read Controller

This block pairs a bus initiator with a bus responder. They talk over a shared set of multiplexed address/data wires using a four-phase request/acknowledge handshake. A local client pulses `start` with an address. The initiator raises its request together with an address strobe. The responder acknowledges, optionally stalls for a programmable number of wait states, and then streams a short burst of data words, each marked by a data-ready strobe and a data strobe on the same wires. The initiator captures each word and hands it to the client. It then closes the handshake and reports completion.

The responder's storage is modelled by a fixed arithmetic function of the word address, so a read has a known value at every address. Only reads are carried. The read/write line therefore shows "read" for the whole of every transfer.

Top module: `bus_read_ctl`

## Requirements
- R1: A synchronous active-high reset returns both machines to idle within one clock. While reset is applied and after it, `enq`, `ack`, `drdy`, `ale`, `dle`, `busy`, `done`, `rdata_vld` and `rd_wr` are low, `ad` is zero and `rdata` is zero.
- R2: `start` is accepted at a rising edge only when `busy` is low. In the next cycle `enq` and `ale` rise and `ad` carries `start_addr`, zero-extended. `ale` stays high for exactly two cycles.
- R3: The responder raises `ack` one cycle after it sees `enq` and `ale` high together while idle. `ack` stays high through the wait and data phases.
- R4: `drdy` first rises exactly `wait_cfg + 1` cycles after `ack` rises, which gives `wait_cfg` wait states (0 to 7). `wait_cfg` is sampled at the edge where the responder accepts the address.
- R5: A read delivers `BURST` data beats in consecutive cycles. Beat b (0-based) carries word_of((A + b) mod 2^AW), where word_of(x) = (x * 40503 XOR 0x5A5A) mod 2^DW.
- R6: `ale` and `dle` are never high in the same cycle. `ad` equals the address while `ale` is high, the data word while `dle` is high, and zero otherwise. `dle` is high exactly when `drdy` is high.
- R7: `rdata_vld` is high for one cycle after each `drdy` cycle, with `rdata` equal to the word that was on `ad`. `rdata` holds its value between beats and between reads.
- R8: `ack` falls in the cycle after the last beat. `enq` stays high in that cycle and falls one cycle later.
- R9: `done` is a one-cycle pulse in the cycle where `enq` falls, with `busy` low. A `start` presented in that cycle is accepted, which gives back-to-back reads.
- R10: A `start` while `busy` is high has no effect on the read in flight, on the data returned, or on later cycles.
- R11: `rd_wr` (1 = read) is high exactly while `enq` is high, and it covers every cycle in which `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read request from the client |
| start_addr | input | AW (8) | Word address of the first beat |
| wait_cfg | input | WW (3) | Responder wait states before data |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Last captured data word |
| rdata_vld | output | 1 | `rdata` was just updated |
| enq | output | 1 | Initiator request line |
| ack | output | 1 | Responder acknowledge line |
| rd_wr | output | 1 | Read/write line, high for read |
| drdy | output | 1 | Data word valid on `ad` |
| ale | output | 1 | Address strobe on shared wires |
| dle | output | 1 | Data strobe on shared wires |
| ad | output | max(AW,DW) (16) | Shared address/data wires |

## Verification
With `wait_cfg` at zero, the initiator drops its address strobe at the same edge where the responder raises its data strobe. A second coincidence comes from `start` being held in the completion cycle: the initiator re-raises `enq` at the same edge where the responder, still releasing, returns to idle. Both cases are driven on purpose: reads at zero wait, and back-to-back reads. A behavioural model predicts every strobe and the shared-wire value in every cycle. The strobes are judged for exclusivity and for the exact cycle of each rise and fall, so a one-cycle overlap or a missed request is caught.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;

  typedef enum logic [1:0] {
    I_IDLE,
    I_ADDR,
    I_WAIT,
    I_DONE
  } ini_st_t;

  typedef enum logic [2:0] {
    R_IDLE,
    R_ADDR,
    R_WAIT,
    R_SEND,
    R_REL
  } rsp_st_t;

  // Content of the modelled store at a word address (truncated by caller).
  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'd40503) ^ 32'h0000_5A5A;
  endfunction

  // Address of a beat within a burst (truncated by caller).
  function automatic logic [31:0] beat_addr(input logic [31:0] base,
                                            input logic [31:0] beat);
    return base + beat;
  endfunction

endpackage

// File: rtl/bus_rd_initiator.sv
module bus_rd_initiator
  import bus_rd_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int BW    = 16,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          ack,
  input  logic          drdy,
  input  logic [BW-1:0] bus_in,
  output logic          enq,
  output logic          ale,
  output logic          rd_wr,
  output logic [AW-1:0] addr_out,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  output logic          take
);

  localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;

  ini_st_t        st;
  logic [AW-1:0]  addr_q;
  logic [BCW-1:0] beat;
  logic           last;

  assign take = (st == I_WAIT) && drdy;
  assign last = (beat == BCW'(BURST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= I_IDLE;
      addr_q    <= '0;
      beat      <= '0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
      done      <= 1'b0;
    end else begin
      rdata_vld <= take;
      done      <= (st == I_DONE) && !ack;
      if (take) rdata <= bus_in[DW-1:0];
      case (st)
        I_IDLE: if (start) begin
          addr_q <= start_addr;
          beat   <= '0;
          st     <= I_ADDR;
        end
        I_ADDR: if (ack) st <= I_WAIT;
        I_WAIT: if (take) begin
          if (last) st <= I_DONE;
          else      beat <= beat + BCW'(1);
        end
        I_DONE: if (!ack) st <= I_IDLE;
        default: st <= I_IDLE;
      endcase
    end
  end

  assign enq      = (st != I_IDLE);
  assign ale      = (st == I_ADDR);
  assign rd_wr    = enq;
  assign busy     = enq;
  assign addr_out = addr_q;

endmodule

// File: rtl/bus_rd_responder.sv
module bus_rd_responder
  import bus_rd_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WW    = 3,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq,
  input  logic          ale,
  input  logic [AW-1:0] bus_addr,
  input  logic [WW-1:0] wait_cfg,
  output logic          ack,
  output logic          drdy,
  output logic          dle,
  output logic [DW-1:0] data_out,
  output logic          accept
);

  localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;

  rsp_st_t        st;
  logic [AW-1:0]  base_q;
  logic [WW-1:0]  cnt;
  logic [BCW-1:0] beat;
  logic [AW-1:0]  cur_addr;

  assign accept   = (st == R_IDLE) && enq && ale;
  assign cur_addr = AW'(beat_addr(32'(base_q), 32'(beat)));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= R_IDLE;
      base_q <= '0;
      cnt    <= '0;
      beat   <= '0;
    end else begin
      case (st)
        R_IDLE: if (accept) begin
          base_q <= bus_addr;
          cnt    <= wait_cfg;
          beat   <= '0;
          st     <= R_ADDR;
        end
        R_ADDR, R_WAIT: begin
          if (cnt == '0) st <= R_SEND;
          else begin
            cnt <= cnt - WW'(1);
            st  <= R_WAIT;
          end
        end
        R_SEND: begin
          if (beat == BCW'(BURST - 1)) st <= R_REL;
          else                         beat <= beat + BCW'(1);
        end
        R_REL: if (!enq) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  assign ack      = (st == R_ADDR) || (st == R_WAIT) || (st == R_SEND);
  assign drdy     = (st == R_SEND);
  assign dle      = drdy;
  assign data_out = DW'(word_of(32'(cur_addr)));

endmodule

// File: rtl/bus_ad_mux.sv
module bus_ad_mux #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int BW = 16
) (
  input  logic          ale,
  input  logic          dle,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [BW-1:0] ad
);

  always_comb begin
    if (ale)      ad = BW'(addr);
    else if (dle) ad = BW'(data);
    else          ad = '0;
  end

endmodule

// File: rtl/bus_read_ctl.sv
module bus_read_ctl #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WW    = 3,
  parameter int BURST = 4,
  localparam int BW   = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [WW-1:0] wait_cfg,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  output logic          enq,
  output logic          ack,
  output logic          rd_wr,
  output logic          drdy,
  output logic          ale,
  output logic          dle,
  output logic [BW-1:0] ad
);

  logic [AW-1:0] ini_addr;
  logic [DW-1:0] rsp_data;
  logic          ini_take;
  logic          rsp_accept;

  bus_rd_initiator #(.AW(AW), .DW(DW), .BW(BW), .BURST(BURST)) u_ini (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_addr(start_addr),
    .ack       (ack),
    .drdy      (drdy),
    .bus_in    (ad),
    .enq       (enq),
    .ale       (ale),
    .rd_wr     (rd_wr),
    .addr_out  (ini_addr),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .rdata_vld (rdata_vld),
    .take      (ini_take)
  );

  bus_rd_responder #(.AW(AW), .DW(DW), .WW(WW), .BURST(BURST)) u_rsp (
    .clk     (clk),
    .rst     (rst),
    .enq     (enq),
    .ale     (ale),
    .bus_addr(ad[AW-1:0]),
    .wait_cfg(wait_cfg),
    .ack     (ack),
    .drdy    (drdy),
    .dle     (dle),
    .data_out(rsp_data),
    .accept  (rsp_accept)
  );

  bus_ad_mux #(.AW(AW), .DW(DW), .BW(BW)) u_mux (
    .ale (ale),
    .dle (dle),
    .addr(ini_addr),
    .data(rsp_data),
    .ad  (ad)
  );

endmodule

// File: rtl/bus_read_ctl_chk.sv
module bus_read_ctl_chk #(
  parameter int WW    = 3,
  parameter int BURST = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [WW-1:0] wait_cfg,
  input logic          enq,
  input logic          ack,
  input logic          rd_wr,
  input logic          drdy,
  input logic          ale,
  input logic          dle,
  input logic          busy,
  input logic          done,
  input logic          rdata_vld,
  input logic          rsp_accept,
  input logic          ini_take
);

  localparam int GW = WW + 1;
  localparam int NW = $clog2(BURST) + 2;

  logic [GW-1:0] gap;
  logic [WW-1:0] wsamp;
  logic [NW-1:0] nbeats;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap    <= '0;
      wsamp  <= '0;
      nbeats <= '0;
    end else begin
      if (ack && !drdy) gap <= gap + GW'(1);
      else              gap <= '0;
      if (rsp_accept) begin
        wsamp  <= wait_cfg;
        nbeats <= '0;
      end else if (drdy) begin
        nbeats <= nbeats + NW'(1);
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !enq && !ack && !drdy && !ale && !dle && !busy && !done && !rdata_vld);

  assert_ack_answers_enq_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) && !$past(rst) |-> enq && $past(enq) && $past(ale));

  assert_wait_count_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy) |-> gap == ({1'b0, wsamp} + GW'(1)));

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) && !$past(rst) |-> nbeats == NW'(BURST));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(ale && dle));

  assert_drdy_inside_hs_R6: assert property (@(posedge clk) disable iff (rst)
    drdy |-> dle && ack && enq && ini_take);

  assert_capture_follows_R7: assert property (@(posedge clk) disable iff (rst)
    rdata_vld |-> $past(drdy));

  assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) && !$past(rst) |-> $past(drdy) && enq);

  assert_enq_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(enq) && !$past(rst) |-> !ack && !$past(ack));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !enq && $past(enq));

  assert_read_line_R11: assert property (@(posedge clk) disable iff (rst)
    (enq || ack) |-> rd_wr);

endmodule

bind bus_read_ctl bus_read_ctl_chk #(.WW(WW), .BURST(BURST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wait_cfg  (wait_cfg),
  .enq       (enq),
  .ack       (ack),
  .rd_wr     (rd_wr),
  .drdy      (drdy),
  .ale       (ale),
  .dle       (dle),
  .busy      (busy),
  .done      (done),
  .rdata_vld (rdata_vld),
  .rsp_accept(rsp_accept),
  .ini_take  (ini_take)
);

// File: tb/sim_bus_read_ctl.sv
module sim_bus_read_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WW = 3;
  localparam int BL = 4;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] start_addr;
  logic [WW-1:0] wait_cfg;
  logic          busy, done, rdata_vld, enq, ack, rd_wr, drdy, ale, dle;
  logic [DW-1:0] rdata;
  logic [BW-1:0] ad;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model state: k = cycles since the accepting edge, -1 idle
  int k = -1;
  int ma = 0;
  int mw = 0;
  int ml = 0;
  int erd = 0;
  bit in_rst = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_read_ctl u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .wait_cfg(wait_cfg), .busy(busy), .done(done), .rdata(rdata),
    .rdata_vld(rdata_vld), .enq(enq), .ack(ack), .rd_wr(rd_wr),
    .drdy(drdy), .ale(ale), .dle(dle), .ad(ad)
  );

  function automatic int wordf(int a);
    return ((a * 40503) ^ 23130) & 65535;
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: got %0h expected %0h",
               in_rst ? "R1" : req, nm, $time, act, exp);
    end
  endtask

  task automatic compare();
    int e_enq, e_ale, e_ack, e_drdy, e_ad, e_rv, e_done;
    e_enq  = (k >= 0 && k <= ml) ? 1 : 0;
    e_ale  = (k == 0 || k == 1) ? 1 : 0;
    e_ack  = (k >= 1 && k <= ml - 1) ? 1 : 0;
    e_drdy = (k >= 2 + mw && k <= ml - 1) ? 1 : 0;
    e_ad   = e_ale ? ma : (e_drdy ? wordf((ma + k - 2 - mw) % 256) : 0);
    e_rv   = (k >= 3 + mw && k <= ml) ? 1 : 0;
    e_done = (k >= 0 && k == ml + 1) ? 1 : 0;
    chk("R2/R8", "enq", int'(enq), e_enq);
    chk("R2", "ale", int'(ale), e_ale);
    chk("R3/R8", "ack", int'(ack), e_ack);
    chk("R4", "drdy", int'(drdy), e_drdy);
    chk("R6", "dle", int'(dle), e_drdy);
    chk("R5", "ad", int'(ad), e_ad);
    chk("R11", "rd_wr", int'(rd_wr), e_enq);
    chk("R9", "busy", int'(busy), e_enq);
    chk("R9", "done", int'(done), e_done);
    chk("R7", "rdata_vld", int'(rdata_vld), e_rv);
    chk("R7/R10", "rdata", int'(rdata), erd);
  endtask

  task automatic step(bit st, int a, bit r);
    start = st;
    start_addr = AW'(a);
    rst = r;
    @(posedge clk);
    in_rst = r;
    if (r) begin
      k = -1;
      erd = 0;
    end else if (st && (k < 0 || k > ml)) begin
      k = 0;
      ma = a;
      mw = int'(wait_cfg);
      ml = 2 + mw + BL;
    end else if (k >= 0) begin
      k++;
      if (k > ml + 1) k = -1;
    end
    if (k >= 3 + mw && k <= ml) erd = wordf((ma + k - 3 - mw) % 256);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // one read; poke = hold start with a foreign address while busy (R10)
  task automatic txn(int a, int w, bit poke);
    wait_cfg = WW'(w);
    step(1, a, 0);
    while (k >= 0 && k <= ml) step(poke, 8'hEE, 0);
  endtask

  initial begin
    start = 0;
    start_addr = '0;
    wait_cfg = '0;
    rst = 1;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    idle(2);
    // R2 R3 R5 R6: zero wait states, ale falls as dle rises
    txn(8'h10, 0, 0);
    idle(3);
    // R4 R10: three wait states, start held high with another address
    txn(8'h3C, 3, 1);
    // R9: back-to-back read accepted in the done cycle
    txn(8'h80, 1, 0);
    // R5: burst wraps the address; R4 longest wait
    txn(8'hFE, 7, 0);
    idle(1);
    // R1: reset in the middle of a read
    wait_cfg = 3'd2;
    step(1, 8'h42, 0);
    idle(5);
    step(0, 0, 1);
    step(0, 0, 1);
    idle(2);
    // R7 R8 R11: normal read after the aborted one
    txn(8'h05, 5, 0);
    idle(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9 watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule